// File: doc/BRIEF.md
# Solenoid Fault Status Serial Slave

This block sits between five solenoid health detectors and a host controller's SPI port. Each detector raises a one-cycle pulse on `fault_set` when it judges its solenoid faulty. The block latches these pulses into sticky flags. When the host selects it, the block shifts out a status byte that holds the five flags in a fixed order. If the frame is long enough, the status byte is followed by the last byte the host sent in the previous accepted frame. That echo lets the host confirm that the serial link is intact.

The host's frame content is never interpreted. Only the frame length matters. The block counts SCLK edges and honours only 8-clock frames or frames of 16 clocks plus whole bytes. Any other length is discarded as a corrupted frame. An accepted frame clears the flags it reported and stores the last received byte for the next echo.

The SPI pins are oversampled by the faster system clock through synchronizers. A host reset input clears all state, and while it is held high every bit shifted out reads as one.

Top module: `sol_fault_spi`

## Requirements
- R1: `sdo_oe` is high while CS is low and low while CS is high. The pad is high-impedance when `sdo_oe` is low.
- R2: Data moves MSB first. SI is captured on SCLK rising edges and SO changes after SCLK falling edges. The status MSB is on SO before the first rising edge.
- R3: The status byte is, from bit 7 down to bit 3: `fault_set[3]`, `fault_set[2]`, `fault_set[1]`, `fault_set[0]`, `fault_set[4]`. Bits 2 to 0 are zero.
- R4: An 8-clock frame returns the status byte. A 16-clock frame returns the status byte followed by the last 8 bits received in the previous accepted frame. That echo byte is zero after reset.
- R5: Frames of 8 clocks, or of 16 + 8k clocks (up to 248), are accepted. A frame of any other length changes neither the flags nor the echo byte.
- R6: The response does not depend on the bits the host sends.
- R7: The flags that a frame reported are cleared when CS rises at the end of an accepted frame.
- R8: A fault pulse that arrives while a frame is in progress is still set after that frame is accepted.
- R9: While `host_reset` is high, flags and echo byte are held at zero, fault pulses are ignored, and every bit on SO reads 1.
- R10: In frames longer than 16 clocks, SO carries the received bits delayed by 16 clocks, so 32 clocks pass a frame through to a second device in a chain.
- R11: SCLK and SI activity while CS is high changes nothing.
- R12: A fault flag stays set across idle time until an accepted frame reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_reset | input | 1 | Active-high host reset; clears state and forces ones on SO |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| fault_set | input | 5 | One-cycle fault pulses; bit n belongs to solenoid n+1 |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for the SO pad |

## Verification
The bench targets the frame-length rule. It runs 12-clock frames between accepted 8-, 16-, 24-, 32- and 40-clock frames. A design that miscounted would clear flags or update the echo byte on the rejected frame, and the next status would come back wrong. Single-channel pulses pin down the bit order of the status byte; a swapped mapping shows up as a set bit in the wrong position. A fault pulse injected mid-frame catches a design that clears every flag at CS rise and loses the late event. Long frames show whether the bits received after the echo byte come back out in order. Idle SCLK toggling with CS high catches a design that counts or shifts unselected. Host-reset frames show whether SO is forced to ones and whether flags and echo come back as zero after release.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int unsigned NSOL   = 5;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned FRAME_W = 2 * BYTE_W;

  // Status byte layout: channels 4,3,2,1,5 (index 3,2,1,0,4) then zero padding
  function automatic logic [BYTE_W-1:0] build_status(input logic [NSOL-1:0] flags);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[BYTE_W-1] = flags[3];
    s[BYTE_W-2] = flags[2];
    s[BYTE_W-3] = flags[1];
    s[BYTE_W-4] = flags[0];
    s[BYTE_W-5] = flags[4];
    return s;
  endfunction
endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end
endmodule

// File: rtl/sfs_shifter.sv
module sfs_shifter #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_s,
  input  logic               sclk_s,
  input  logic               sdi_s,
  input  logic [FRAME_W-1:0] load_word,
  output logic               sel,
  output logic               sdo_q,
  output logic               xfer_start,
  output logic               xfer_accept,
  output logic [BYTE_W-1:0]  rx_byte,
  output logic [CNT_W-1:0]   bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_W);
  localparam int unsigned      ALIGN_B   = $clog2(BYTE_W);

  logic               cs_d, sclk_d;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic               sdo_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               cs_fall, cs_rise, sclk_rise, sclk_fall, len_ok;

  assign sel       = ~cs_s;
  assign cs_fall   = cs_d & ~cs_s;
  assign cs_rise   = ~cs_d & cs_s;
  assign sclk_rise = sel & sclk_s & ~sclk_d;
  assign sclk_fall = sel & ~sclk_s & sclk_d;

  assign len_ok = (cnt_q == LEN_SHORT) ||
                  ((cnt_q >= LEN_LONG) && (cnt_q[ALIGN_B-1:0] == '0));

  assign xfer_start  = cs_fall;
  assign xfer_accept = cs_rise & len_ok;
  assign rx_byte     = sh_q[BYTE_W-1:0];
  assign bit_cnt     = cnt_q;

  always_comb begin
    sh_n  = sh_q;
    sdo_n = sdo_q;
    cnt_n = cnt_q;
    if (cs_fall) begin
      sh_n  = load_word;
      sdo_n = load_word[FRAME_W-1];
      cnt_n = '0;
    end else if (sclk_rise) begin
      sh_n = {sh_q[FRAME_W-2:0], sdi_s};
      if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
    end else if (sclk_fall && (cnt_q != '0)) begin
      sdo_n = sh_q[FRAME_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
      sh_q   <= '0;
      sdo_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
      sh_q   <= sh_n;
      sdo_q  <= sdo_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/sfs_fault_bank.sv
module sfs_fault_bank #(
  parameter int unsigned NSOL = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_all,
  input  logic [NSOL-1:0] set_in,
  input  logic            xfer_start,
  input  logic            xfer_accept,
  output logic [NSOL-1:0] flags_q
);
  logic [NSOL-1:0] late_q, late_n, flags_n;

  // late_q gathers events since the status snapshot; accept keeps only those
  always_comb begin
    flags_n = flags_q | set_in;
    late_n  = late_q | set_in;
    if (clr_all) begin
      flags_n = '0;
      late_n  = '0;
    end else if (xfer_accept) begin
      flags_n = late_q | set_in;
      late_n  = '0;
    end else if (xfer_start) begin
      late_n = set_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      late_q  <= '0;
    end else begin
      flags_q <= flags_n;
      late_q  <= late_n;
    end
  end
endmodule

// File: rtl/sol_fault_spi.sv
module sol_fault_spi
  import sfs_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_reset,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            sdi,
  input  logic [NSOL-1:0] fault_set,
  output logic            sdo,
  output logic            sdo_oe
);
  logic               host_rst_s, cs_s, sclk_s, sdi_s;
  logic               sel, sdo_q, xfer_start, xfer_accept;
  logic [BYTE_W-1:0]  rx_byte;
  logic [CNT_W-1:0]   bit_cnt;
  logic [NSOL-1:0]    fault_q;
  logic [BYTE_W-1:0]  echo_q, echo_n;
  logic [FRAME_W-1:0] load_word;

  sfs_sync #(.W(4), .RST_VAL(4'b0100)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({host_reset, cs_n, sclk, sdi}),
    .q     ({host_rst_s, cs_s, sclk_s, sdi_s})
  );

  assign load_word = {build_status(fault_q), echo_q};

  sfs_shifter #(.FRAME_W(FRAME_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) i_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (cs_s),
    .sclk_s      (sclk_s),
    .sdi_s       (sdi_s),
    .load_word   (load_word),
    .sel         (sel),
    .sdo_q       (sdo_q),
    .xfer_start  (xfer_start),
    .xfer_accept (xfer_accept),
    .rx_byte     (rx_byte),
    .bit_cnt     (bit_cnt)
  );

  sfs_fault_bank #(.NSOL(NSOL)) i_faults (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_all     (host_rst_s),
    .set_in      (fault_set),
    .xfer_start  (xfer_start),
    .xfer_accept (xfer_accept),
    .flags_q     (fault_q)
  );

  always_comb begin
    echo_n = echo_q;
    if (host_rst_s)       echo_n = '0;
    else if (xfer_accept) echo_n = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) echo_q <= '0;
    else        echo_q <= echo_n;
  end

  assign sdo    = host_rst_s | sdo_q;
  assign sdo_oe = sel;
endmodule

// File: rtl/sol_fault_spi_chk.sv
module sol_fault_spi_chk #(
  parameter int unsigned NSOL  = 5,
  parameter int unsigned CNT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            host_reset,
  input logic            cs_n,
  input logic            sdo,
  input logic            sdo_oe,
  input logic [NSOL-1:0] fault_set,
  input logic            host_rst_s,
  input logic [NSOL-1:0] fault_q,
  input logic [7:0]      echo_q,
  input logic [CNT_W-1:0] bit_cnt
);
  a_r1_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !sdo_oe);

  a_r9_reset_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (host_reset && $past(host_reset) && $past(host_reset, 2) && $past(host_reset, 3)) |-> sdo);

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (host_reset && $past(host_reset) && $past(host_reset, 2) && $past(host_reset, 3))
      |-> (fault_q == '0) && (echo_q == '0));

  a_r8_pulse_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_set != '0) && !host_rst_s) |=> ((fault_q & $past(fault_set)) == $past(fault_set)));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_oe && !$past(sdo_oe) && !$past(sdo_oe, 2) && !host_rst_s && !$past(host_rst_s))
      |-> ($stable(echo_q) && $stable(bit_cnt)));
endmodule

bind sol_fault_spi sol_fault_spi_chk #(.NSOL(sfs_pkg::NSOL), .CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_reset (host_reset),
  .cs_n       (cs_n),
  .sdo        (sdo),
  .sdo_oe     (sdo_oe),
  .fault_set  (fault_set),
  .host_rst_s (host_rst_s),
  .fault_q    (fault_q),
  .echo_q     (echo_q),
  .bit_cnt    (bit_cnt)
);

// File: tb/test_sol_fault_spi.sv
module test_sol_fault_spi;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_reset = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic [4:0] fault_set = '0;
  logic       sdo, sdo_oe;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [4:0] m_fault = '0;
  logic [7:0] m_echo  = '0;
  bit         m_hrst  = 0;

  always #10 clk = ~clk;

  sol_fault_spi i_sol_fault_spi (
    .clk(clk), .rst_n(rst_n), .host_reset(host_reset), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .fault_set(fault_set), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] status_of(input logic [4:0] f);
    return {f[3], f[2], f[1], f[0], f[4], 3'b000};
  endfunction

  task automatic pulse(input logic [4:0] m);
    @(negedge clk);
    fault_set = m;
    @(negedge clk);
    fault_set = '0;
    if (!m_hrst) m_fault |= m;
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [63:0] data, input logic [4:0] mid, input string req);
    bit q[$];
    logic [7:0] st;
    logic [4:0] late;
    bit accept;
    st = status_of(m_fault);
    late = '0;
    for (int b = 7; b >= 0; b--) q.push_back(st[b]);
    for (int b = 7; b >= 0; b--) q.push_back(m_echo[b]);
    for (int b = n - 1; b >= 0; b--) q.push_back(data[b]);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    chk(sdo_oe === 1'b1, "R1", "oe while selected", int'(sdo_oe), 1);
    for (int i = 0; i < n; i++) begin
      sdi = data[n-1-i];
      if (i == 3 && mid != '0) begin
        fault_set = mid;
        @(negedge clk);
        fault_set = '0;
        if (!m_hrst) begin
          late |= mid;
          m_fault |= mid;
        end
      end
      repeat (6) @(negedge clk);
      begin
        bit e;
        e = m_hrst ? 1'b1 : q[i];
        chk(sdo === e, req, $sformatf("bit %0d of %0d-clock frame", i, n), int'(sdo), int'(e));
      end
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(sdo_oe === 1'b0, "R1", "oe after deselect", int'(sdo_oe), 0);
    accept = (n == 8) || (n >= 16 && n % 8 == 0);
    if (accept && !m_hrst) begin
      m_echo  = data[7:0];
      m_fault = late;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo_oe === 1'b0, "R1", "oe after reset", int'(sdo_oe), 0);

    // R4 R6 R2: zero status, zero echo after reset
    xfer(16, 64'hA5C3, 5'b0, "R4");
    // R3 R7 R12: two flags latched across idle, then reported
    pulse(5'b01001);
    repeat (20) @(negedge clk);
    xfer(16, 64'h1234, 5'b0, "R12");
    // R7 R6: cleared after accepted frame, different payload
    xfer(8, 64'h5A, 5'b0, "R7");
    // R5: 12-clock frame rejected, then state unchanged
    pulse(5'b10000);
    xfer(12, 64'hABC, 5'b0, "R5");
    xfer(16, 64'hFFFF, 5'b0, "R5");
    // R10: longer accepted frames pass received bits through
    xfer(24, 64'h0F1E2D, 5'b0, "R10");
    xfer(32, 64'hDEADBEEF, 5'b0, "R10");
    xfer(40, 64'h0123456789, 5'b0, "R10");
    xfer(17, 64'h1FFFF, 5'b0, "R5");
    // R8: pulse during frame survives
    xfer(16, 64'h0000, 5'b00110, "R8");
    xfer(8, 64'h3C, 5'b0, "R8");
    // R3: each channel alone
    for (int ch = 0; ch < 5; ch++) begin
      pulse(5'(1 << ch));
      xfer(8, 64'(8'h60 + ch), 5'b0, "R3");
    end
    // R11: activity while deselected
    for (int k = 0; k < 10; k++) begin
      sdi = k[0];
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      chk(sdo_oe === 1'b0, "R11", "oe while clocking unselected", int'(sdo_oe), 0);
    end
    xfer(16, 64'h7E81, 5'b0, "R11");
    // R9: host reset
    pulse(5'b11111);
    @(negedge clk);
    host_reset = 1'b1;
    m_hrst = 1;
    m_fault = '0;
    m_echo = '0;
    repeat (6) @(negedge clk);
    pulse(5'b00010);
    xfer(16, 64'h9999, 5'b0, "R9");
    xfer(8, 64'h42, 5'b0, "R9");
    @(negedge clk);
    host_reset = 1'b0;
    m_hrst = 0;
    repeat (6) @(negedge clk);
    xfer(16, 64'h1111, 5'b0, "R9");
    xfer(16, 64'h2222, 5'b0, "R4");

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule